// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Steering

This block sits between a 32-bit processor core and a 32-bit memory bus that numbers its bytes big-endian, with the lowest byte address on the most significant data lane. For a store, it turns the transfer size, the two low address bits and the direction flag into four byte-lane write enables and hands the store data to the bus unchanged. For a load, it takes the word the memory returns and shapes it into a register value. A word read from a non-aligned offset is rotated rather than faulted. Bytes and halfwords are picked from their lanes and zero-extended.

A request is offered with `req_valid` and taken in any cycle where `req_ready` is high. Write enables and the reserved-size flag are combinational in the cycle the request is taken, and the memory read data is expected in that same cycle. Load results are registered and appear with `ld_valid` one cycle later. A read marked as a 16-bit instruction fetch returns the fetched word as two zero-extended halfwords on consecutive cycles, the lower-addressed half first. While the second half is pending, `req_ready` is held low.

Top module: `be_lane_steer`

## Requirements
- R1: Memory byte offset k (k = 0..3) lives on data bits [31-8k : 24-8k], so offset 0 is on bits 31:24 and offset 3 is on bits 7:0. Write-enable bit `mem_we[3-k]` controls the lane of offset k.
- R2: A request taken with `req_write` = 0 drives `mem_we` = 4'b0000 for every size and address.
- R3: A byte store (size 2'b00) at offsets 0, 1, 2 and 3 drives `mem_we` = 4'b1000, 4'b0100, 4'b0010 and 4'b0001 respectively.
- R4: A halfword store (size 2'b01) drives 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. Address bit 0 has no effect.
- R5: A word store (size 2'b10) drives 4'b1111 at every offset.
- R6: A request taken with size 2'b11 and `req_fetch` = 0 raises `size_err` in the same cycle, drives `mem_we` = 0 and produces no `ld_valid`.
- R7: A word load at offset n returns `mem_rdata` rotated right by 8n bits. For memory word 0x76543210, offsets 0..3 give 0x76543210, 0x10765432, 0x32107654 and 0x54321076.
- R8: Byte loads return the addressed lane zero-extended (0x76, 0x54, 0x32, 0x10 for the word above). Halfword loads return bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1, zero-extended, with address bit 0 ignored (0x7654 and 0x3210).
- R9: `mem_wdata` equals `st_data` bit for bit, with no rotation, for every size and offset.
- R10: After reset `ld_valid` is 0, `ld_data` is 0 and `req_ready` is 1. For a normal load, `ld_valid` is high for exactly the one cycle after the request is taken, carrying the result.
- R11: A read taken with `req_fetch` = 1 ignores size and address. It gives `ld_valid` on the next two cycles, first with bits 31:16 and then with bits 15:0, both zero-extended, and `req_ready` is low during the first of those two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | 2 | Low byte-address bits |
| req_fetch | input | 1 | Load is a 16-bit instruction fetch |
| st_data | input | 32 | Store data from the core |
| mem_rdata | input | 32 | Memory read data, same cycle as the request |
| mem_we | output | 4 | Byte-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Store data to memory |
| size_err | output | 1 | Reserved size code seen on a taken request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
Write enables, store data and the reserved-size flag are due in the cycle the request is taken. The bench drives each request just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. Load results are due one rising edge after acceptance, so the bench samples `ld_valid` and `ld_data` just after that edge and checks that `ld_valid` has dropped after the following edge. For instruction fetches it checks the second half after the second edge and checks that `req_ready` is low in between.

// File: rtl/be_lane_pkg.sv
// Package: shared size codes and bus geometry for the big-endian lane
// steering block. Assumes byte lanes and an even lane count.
package be_lane_pkg;

    localparam int unsigned LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

endpackage

// File: rtl/be_we_decode.sv
// Module: be_we_decode
// Turns a taken store's size and low address into per-lane write
// enables. Lane k of memory sits on the k-th most significant byte, so
// enable bit NUM_LANES-1-k belongs to offset k. Assumes the caller gates
// 'take' with the handshake.
module be_we_decode
    import be_lane_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned OFS_W = $clog2(NUM_LANES)
) (
    input  logic                 take,
    input  logic                 is_write,
    input  logic                 is_fetch,
    input  logic [1:0]           size,
    input  logic [OFS_W-1:0]     ofs,
    output logic [NUM_LANES-1:0] we,
    output logic                 rsvd
);

    logic store_ok;

    // Purpose: qualify a store and flag the reserved size code.
    always_comb begin
        rsvd     = take && !is_fetch && (size == SZ_RSVD);
        store_ok = take && is_write && (size != SZ_RSVD);
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic byte_hit;
        logic half_hit;
        // Purpose: decide whether memory offset g is written.
        always_comb begin
            byte_hit = (ofs == OFS_W'(g));
            half_hit = (ofs[OFS_W-1] == 1'((g * 2) / NUM_LANES));
            unique case (size)
                SZ_BYTE: we[NUM_LANES-1-g] = store_ok && byte_hit;
                SZ_HALF: we[NUM_LANES-1-g] = store_ok && half_hit;
                SZ_WORD: we[NUM_LANES-1-g] = store_ok;
                default: we[NUM_LANES-1-g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/be_load_steer.sv
// Module: be_load_steer
// Combinational shaping of a big-endian memory word into a register
// value: rotate for words, lane pick plus zero-extension for bytes and
// halfwords, and the two fetch halves. Assumes NUM_LANES is even.
module be_load_steer
    import be_lane_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned DATA_W = NUM_LANES * LANE_W,
    localparam int unsigned HALF_W = DATA_W / 2,
    localparam int unsigned OFS_W  = $clog2(NUM_LANES),
    localparam int unsigned LB_W   = $clog2(LANE_W),
    localparam int unsigned SH_W   = OFS_W + LB_W
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    output logic [DATA_W-1:0] result,
    output logic [HALF_W-1:0] fetch_hi,
    output logic [HALF_W-1:0] fetch_lo
);

    logic [LANE_W-1:0]   lane [NUM_LANES];
    logic [HALF_W-1:0]   half [2];
    logic [2*DATA_W-1:0] doubled;
    logic [2*DATA_W-1:0] shifted;
    logic [SH_W-1:0]     shamt;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Purpose: name memory offset g by its big-endian lane.
        assign lane[g] = rdata[(NUM_LANES-1-g)*LANE_W +: LANE_W];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        // Purpose: name halfword h, the lower address on the upper bits.
        assign half[h] = rdata[(1-h)*HALF_W +: HALF_W];
    end

    // Purpose: rotate right by whole lanes for non-aligned word loads.
    always_comb begin
        shamt   = {ofs, {LB_W{1'b0}}};
        doubled = {rdata, rdata};
        shifted = doubled >> shamt;
    end

    // Purpose: choose the load result by size.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = DATA_W'(lane[ofs]);
            SZ_HALF: result = DATA_W'(half[ofs[OFS_W-1]]);
            SZ_WORD: result = shifted[DATA_W-1:0];
            default: result = '0;
        endcase
    end

    // Purpose: fetch halves in address order.
    always_comb begin
        fetch_hi = half[0];
        fetch_lo = half[1];
    end

endmodule

// File: rtl/be_load_pipe.sv
// Module: be_load_pipe
// Registers the load result and sequences the two-beat instruction
// fetch. Assumes no new load is taken while a second beat is pending
// (enforced through 'busy').
module be_load_pipe #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_load,
    input  logic              take_fetch,
    input  logic [DATA_W-1:0] load_val,
    input  logic [HALF_W-1:0] fetch_hi,
    input  logic [HALF_W-1:0] fetch_lo,
    output logic              busy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              pend_q;
    logic [HALF_W-1:0] lo_q;

    // Purpose: load result register and second-beat holding state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            pend_q    <= 1'b0;
            lo_q      <= '0;
        end else if (take_fetch) begin
            out_valid <= 1'b1;
            out_data  <= DATA_W'(fetch_hi);
            pend_q    <= 1'b1;
            lo_q      <= fetch_lo;
        end else if (take_load) begin
            out_valid <= 1'b1;
            out_data  <= load_val;
            pend_q    <= 1'b0;
        end else if (pend_q) begin
            out_valid <= 1'b1;
            out_data  <= DATA_W'(lo_q);
            pend_q    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
        end
    end

    assign busy = pend_q;

endmodule

// File: rtl/be_lane_steer.sv
// Module: be_lane_steer (top)
// Lane steering between a core and a big-endian 32-bit memory bus:
// store write enables, load shaping and a registered result. Assumes the
// memory returns read data in the cycle the request is taken.
module be_lane_steer
    import be_lane_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    localparam int unsigned DATA_W = NUM_LANES * LANE_W,
    localparam int unsigned HALF_W = DATA_W / 2,
    localparam int unsigned OFS_W  = $clog2(NUM_LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [OFS_W-1:0]     req_addr,
    input  logic                 req_fetch,
    input  logic [DATA_W-1:0]    st_data,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [NUM_LANES-1:0] mem_we,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 size_err,
    output logic                 ld_valid,
    output logic [DATA_W-1:0]    ld_data
);

    logic              take;
    logic              take_load;
    logic              take_fetch;
    logic              busy;
    logic [DATA_W-1:0] load_val;
    logic [HALF_W-1:0] fetch_hi;
    logic [HALF_W-1:0] fetch_lo;

    // Purpose: handshake and classification of the taken request.
    always_comb begin
        req_ready  = !busy;
        take       = req_valid && req_ready;
        take_fetch = take && !req_write && req_fetch;
        take_load  = take && !req_write && !req_fetch && (req_size != SZ_RSVD);
    end

    // Purpose: store data goes out unrotated.
    assign mem_wdata = st_data;

    be_we_decode #(.NUM_LANES(NUM_LANES)) u_we (
        .take     (take),
        .is_write (req_write),
        .is_fetch (req_fetch),
        .size     (req_size),
        .ofs      (req_addr),
        .we       (mem_we),
        .rsvd     (size_err)
    );

    be_load_steer #(.NUM_LANES(NUM_LANES)) u_steer (
        .rdata    (mem_rdata),
        .size     (req_size),
        .ofs      (req_addr),
        .result   (load_val),
        .fetch_hi (fetch_hi),
        .fetch_lo (fetch_lo)
    );

    be_load_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_load  (take_load),
        .take_fetch (take_fetch),
        .load_val   (load_val),
        .fetch_hi   (fetch_hi),
        .fetch_lo   (fetch_lo),
        .busy       (busy),
        .out_valid  (ld_valid),
        .out_data   (ld_data)
    );

endmodule

// File: rtl/be_lane_steer_chk.sv
// Module: be_lane_steer_chk
// Protocol and decode properties of be_lane_steer, bound to the top.
module be_lane_steer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        req_fetch,
    input logic [3:0]  mem_we,
    input logic        size_err,
    input logic        ld_valid
);

    logic take;
    assign take = req_valid && req_ready;

    // R2: loads never write
    a_r2_load_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_write) |-> (mem_we == 4'b0000));

    // R3: a byte store writes exactly one lane
    a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_write && req_size == 2'b00) |-> ($countones(mem_we) == 1));

    // R6: reserved size flags and writes nothing
    a_r6_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_fetch && req_size == 2'b11) |-> (size_err && mem_we == 4'b0000));

    // R6: reserved read gives no result
    a_r6_rsvd_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_write && !req_fetch && req_size == 2'b11) |=> !ld_valid);

    // R10: normal load result one cycle later
    a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_write && !req_fetch && req_size != 2'b11) |=> ld_valid);

    // R11: fetch stalls intake, then second beat
    a_r11_fetch_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_write && req_fetch) |=> (!req_ready && ld_valid));

    a_r11_fetch_beat2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_write && req_fetch) |=> ##1 ld_valid);

endmodule

bind be_lane_steer be_lane_steer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .req_fetch (req_fetch),
    .mem_we    (mem_we),
    .size_err  (size_err),
    .ld_valid  (ld_valid)
);

// File: tb/be_lane_steer_tb.sv
module be_lane_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [1:0]  req_addr = 2'b00;
    logic        req_fetch = 1'b0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        size_err;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    be_lane_steer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_fetch(req_fetch), .st_data(st_data), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .size_err(size_err),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Offer a request just after a falling edge; results of the cycle at +1 ns.
    task automatic offer(input logic wr, input logic [1:0] sz, input logic [1:0] a,
                         input logic f, input logic [31:0] sd, input logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_fetch = f; st_data = sd; mem_rdata = rd;
        #1;
    endtask

    task automatic idle_after_edge();
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    endtask

    function automatic logic [3:0] exp_we(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00: return 4'b1000 >> a;
            2'b01: return a[1] ? 4'b0011 : 4'b1100;
            2'b10: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic t_reset();
        chk("R10 reset ld_valid", 32'(ld_valid), 32'd0);
        chk("R10 reset ld_data", ld_data, 32'd0);
        chk("R10 reset req_ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_store_enables();
        for (int s = 0; s < 3; s++) begin
            for (int a = 0; a < 4; a++) begin
                offer(1'b1, 2'(s), 2'(a), 1'b0, 32'hA1B2C3D4 ^ 32'(a), 32'h0);
                chk(s == 0 ? "R3 R1 byte store we" : (s == 1 ? "R4 half store we" : "R5 word store we"),
                    32'(mem_we), 32'(exp_we(2'(s), 2'(a))));
                chk("R9 store data unrotated", mem_wdata, 32'hA1B2C3D4 ^ 32'(a));
                chk("R6 no size_err on valid size", 32'(size_err), 32'd0);
                idle_after_edge();
            end
        end
    endtask

    task automatic t_reads_no_we();
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                offer(1'b0, 2'(s), 2'(a), 1'b0, 32'hFFFFFFFF, 32'h76543210);
                chk("R2 read drives no we", 32'(mem_we), 32'd0);
                idle_after_edge();
            end
        end
    endtask

    task automatic t_reserved();
        offer(1'b1, 2'b11, 2'b10, 1'b0, 32'h12345678, 32'h0);
        chk("R6 rsvd store size_err", 32'(size_err), 32'd1);
        chk("R6 rsvd store we", 32'(mem_we), 32'd0);
        idle_after_edge();
        offer(1'b0, 2'b11, 2'b01, 1'b0, 32'h0, 32'h76543210);
        chk("R6 rsvd load size_err", 32'(size_err), 32'd1);
        idle_after_edge();
        chk("R6 rsvd load no ld_valid", 32'(ld_valid), 32'd0);
    endtask

    task automatic load_check(input string req, input logic [1:0] sz, input logic [1:0] a,
                              input logic [31:0] rd, input logic [31:0] exp);
        offer(1'b0, sz, a, 1'b0, 32'h0, rd);
        idle_after_edge();
        chk({req, " ld_valid"}, 32'(ld_valid), 32'd1);
        chk(req, ld_data, exp);
        @(posedge clk); #1;
        chk("R10 ld_valid one cycle", 32'(ld_valid), 32'd0);
    endtask

    task automatic t_word_loads();
        logic [31:0] ref_w [4] = '{32'h76543210, 32'h10765432, 32'h32107654, 32'h54321076};
        for (int a = 0; a < 4; a++)
            load_check("R7 word load", 2'b10, 2'(a), 32'h76543210, ref_w[a]);
        for (int a = 0; a < 4; a++) begin
            logic [31:0] m = 32'hA1B2C3D4;
            logic [63:0] d = {m, m} >> (8 * a);
            load_check("R7 word load alt", 2'b10, 2'(a), m, d[31:0]);
        end
    endtask

    task automatic t_sub_loads();
        logic [31:0] ref_b [4] = '{32'h76, 32'h54, 32'h32, 32'h10};
        for (int a = 0; a < 4; a++)
            load_check("R8 R1 byte load", 2'b00, 2'(a), 32'h76543210, ref_b[a]);
        for (int a = 0; a < 4; a++) begin
            logic [31:0] m = 32'hF0E1D2C3;
            load_check("R8 byte load zext", 2'b00, 2'(a), m, {24'h0, m[31-8*a -: 8]});
        end
        for (int a = 0; a < 4; a++)
            load_check("R8 half load", 2'b01, 2'(a), 32'h76543210,
                       (a >= 2) ? 32'h3210 : 32'h7654);
        load_check("R8 half load zext", 2'b01, 2'b11, 32'h89ABCDEF, 32'h0000CDEF);
    endtask

    task automatic t_fetch();
        for (int a = 0; a < 4; a++) begin
            offer(1'b0, 2'(a), 2'(3 - a), 1'b1, 32'h0, 32'h76543210);
            idle_after_edge();
            mem_rdata = 32'hDEADBEEF;
            chk("R11 fetch beat1 valid", 32'(ld_valid), 32'd1);
            chk("R11 fetch beat1 upper", ld_data, 32'h00007654);
            chk("R11 ready low", 32'(req_ready), 32'd0);
            @(posedge clk); #1;
            chk("R11 fetch beat2 valid", 32'(ld_valid), 32'd1);
            chk("R11 fetch beat2 lower", ld_data, 32'h00003210);
            chk("R11 ready back", 32'(req_ready), 32'd1);
            @(posedge clk); #1;
            chk("R10 ld_valid drops", 32'(ld_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_store_enables();
        t_reads_no_we();
        t_reserved();
        t_word_loads();
        t_sub_loads();
        t_fetch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule